// File: doc/BRIEF.md
# Flag-Setting Adder/Subtractor

This block adds or subtracts two 32-bit operands and keeps a four-bit status register with negative, zero, carry and overflow flags. A caller presents both operands, an add/subtract select and a flag-update control together with a one-cycle valid strobe. The registered result appears on the clock edge that follows the strobe, and a result-valid output marks that cycle.

Subtraction is formed as A plus the inverted B with a carry-in of one, so a carry of one after a subtract means no borrow occurred. Addition uses a carry-in of zero. Carry is raised when the truncated result, read as unsigned, differs from the full-precision unsigned sum. Overflow is raised when the truncated result, read as signed, differs from the full-precision signed sum of the sign-extended operands and the carry-in.

The flag-update control decides only whether the status register is written. The result is identical either way. Reset is synchronous and active low.

Top module: `addsub_flag_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result`, `result_valid` and all four flags become 0.
- R2: With `op_sub`=0, `result` equals (`opa` + `opb`) modulo 2^32 one cycle after a strobe.
- R3: With `op_sub`=1, `result` equals (`opa` - `opb`) modulo 2^32 one cycle after a strobe.
- R4: `result` does not depend on `op_setflags`.
- R5: After a strobe with `op_setflags`=1, `flag_n` equals bit 31 of the new result, and `flag_z` is 1 exactly when all 32 result bits are 0.
- R6: After a flag-setting add, `flag_c` is the carry out of the 33-bit unsigned sum.
- R7: After a flag-setting subtract, `flag_c` is 1 exactly when `opa` >= `opb` as unsigned values (no borrow).
- R8: After a flag-setting operation, `flag_v` is 1 exactly when the signed result does not fit in 32 bits. For an add, this means both operands have the same sign and the result's sign differs. For a subtract, it means the operands' signs differ and the result's sign differs from `opa`.
- R9: After a strobe with `op_setflags`=0, all four flags keep their previous values.
- R10: With `op_valid`=0, `result` and the flags hold their values whatever the other inputs are.
- R11: `result_valid` is 1 in exactly the cycle after each cycle in which `op_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| op_setflags | input | 1 | 1 = write the status register with this operation's flags |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| result | output | 32 | Registered result |
| result_valid | output | 1 | Result updated on the last edge |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow for subtract) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The result, `result_valid` and the flags are all due exactly one rising edge after the strobe. Each scenario task therefore drives its inputs on a falling edge and samples the outputs on the next falling edge, halfway between the capturing edge and the following one. The idle and no-flag scenarios keep sampling on later falling edges, while the inputs are changing, to confirm that the held values have not moved.

// File: rtl/addsub_flag_pkg.sv
// Shared types for the flag-setting adder/subtractor.
// Assumes: the four flags always travel together as one packed word.
package addsub_flag_pkg;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } status_t;

    localparam status_t STATUS_CLEAR = '0;

endpackage

// File: rtl/afu_operand_prep.sv
// Operand preparation: selects the second adder operand and the carry-in.
// Assumes: subtract is A + ~B + 1, and add is A + B + 0.
module afu_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic             op_sub,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_in
);

    // Invert B and force carry-in high for subtract.
    always_comb begin
        b_eff    = op_sub ? ~opb : opb;
        carry_in = op_sub;
    end

endmodule

// File: rtl/afu_sum_core.sv
// Sum core: truncated sum plus all four flags.
// Carry and overflow come from comparing the truncated sum with
// full-precision unsigned and signed sums.
// Assumes: operands are already prepared (B inverted for subtract).
module afu_sum_core
    import addsub_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output status_t          flags
);

    localparam int UW = WIDTH + 1;
    localparam int SW = WIDTH + 2;

    logic [UW-1:0] usum_full;
    logic [SW-1:0] ssum_full;

    // Full-precision unsigned and sign-extended sums.
    always_comb begin
        usum_full = {1'b0, a} + {1'b0, b} + UW'(cin);
        ssum_full = {{2{a[WIDTH-1]}}, a} + {{2{b[WIDTH-1]}}, b} + SW'(cin);
    end

    // Truncate, then compare against the wide sums.
    always_comb begin
        sum         = usum_full[WIDTH-1:0];
        flags.neg   = sum[WIDTH-1];
        flags.zero  = ~|sum;
        flags.carry = ({1'b0, sum} != usum_full);
        flags.ovf   = ({{2{sum[WIDTH-1]}}, sum} != ssum_full);
    end

endmodule

// File: rtl/afu_status_reg.sv
// Status register: holds the four flags and writes them only when asked.
// Assumes: synchronous active-low reset clears all flags.
module afu_status_reg
    import addsub_flag_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  status_t status_in,
    output status_t status_q
);

    // Capture new flags on a write and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= STATUS_CLEAR;
        else if (wr_en)
            status_q <= status_in;
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q)); // R9

    AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (status_q == $past(status_in))); // R5

endmodule

// File: rtl/addsub_flag_unit.sv
// Top level: a registered 32-bit add/subtract with a gated flag write.
// Assumes: one operation per strobe; result and flags are due one edge later.
module addsub_flag_unit
    import addsub_flag_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic             op_setflags,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             result_valid,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    logic [WIDTH-1:0] b_eff;
    logic             carry_in;
    logic [WIDTH-1:0] sum_w;
    status_t          flags_w;
    status_t          status_q;
    logic [WIDTH-1:0] result_q;
    logic             valid_q;

    afu_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .op_sub   (op_sub),
        .opb      (opb),
        .b_eff    (b_eff),
        .carry_in (carry_in)
    );

    afu_sum_core #(.WIDTH(WIDTH)) u_core (
        .a     (opa),
        .b     (b_eff),
        .cin   (carry_in),
        .sum   (sum_w),
        .flags (flags_w)
    );

    afu_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (op_valid && op_setflags),
        .status_in (flags_w),
        .status_q  (status_q)
    );

    // Result register: loads on a strobe, independent of the flag control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= op_valid;
            if (op_valid)
                result_q <= sum_w;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        result       = result_q;
        result_valid = valid_q;
        flag_n       = status_q.neg;
        flag_z       = status_q.zero;
        flag_c       = status_q.carry;
        flag_v       = status_q.ovf;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> result_valid); // R11

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !result_valid); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result)); // R10

    AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_setflags) |=> (flag_n == result[WIDTH-1])); // R5

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_setflags) |=> (flag_z == (result == '0))); // R5

endmodule

// File: tb/test_addsub_flag_unit.sv
module test_addsub_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic        op_setflags = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        result_valid;
    logic        flag_n, flag_z, flag_c, flag_v;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    logic [3:0] exp_flags = 4'b0;

    always #10 clk = ~clk;

    addsub_flag_unit i_addsub_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .op_setflags(op_setflags), .opa(opa), .opb(opb), .result(result),
        .result_valid(result_valid), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected result and flags, using comparison rules rather than wide sums.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         output logic [31:0] r, output logic [3:0] f);
        logic [32:0] w;
        logic c, v;
        if (!sub) begin
            w = {1'b0, a} + {1'b0, b};
            r = w[31:0];
            c = w[32];
            v = (a[31] == b[31]) && (r[31] != a[31]);
        end else begin
            r = a - b;
            c = (a >= b);
            v = (a[31] != b[31]) && (r[31] != a[31]);
        end
        f = {r[31], (r == 32'h0), c, v};
    endtask

    // Strobe one operation and check the outputs one edge later.
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic sub, input logic sf);
        logic [31:0] r;
        logic [3:0]  f;
        model(a, b, sub, r, f);
        if (sf) exp_flags = f;
        @(negedge clk);
        opa = a; opb = b; op_sub = sub; op_setflags = sf; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " result"}, result, r);
        check({req, " valid"}, {31'b0, result_valid}, 32'h1);
        check({req, " flags NZCV"}, {28'b0, flag_n, flag_z, flag_c, flag_v}, {28'b0, exp_flags});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 result", result, 32'h0);
        check("R1 valid", {31'b0, result_valid}, 32'h0);
        check("R1 flags", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
        rst_n = 1'b1;
        exp_flags = 4'b0;
    endtask

    task automatic t_add;
        run_op("R2", 32'd1234, 32'd4321, 1'b0, 1'b1);
        run_op("R6 wrap", 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        run_op("R8 pos ovf", 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
        run_op("R8 neg ovf", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
        run_op("R5 neg", 32'hFFFF_FFF0, 32'h5, 1'b0, 1'b1);
    endtask

    task automatic t_sub;
        run_op("R3", 32'd9000, 32'd123, 1'b1, 1'b1);
        run_op("R7 equal", 32'd5, 32'd5, 1'b1, 1'b1);
        run_op("R7 borrow", 32'd3, 32'd5, 1'b1, 1'b1);
        run_op("R8 sub ovf", 32'h8000_0000, 32'h1, 1'b1, 1'b1);
        run_op("R8 sub ovf2", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_noflag;
        // Establish known flags, then run flag-free ops that would change them.
        run_op("R9 setup", 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1);
        run_op("R9 add hold R4", 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
        run_op("R9 sub hold R4", 32'd3, 32'd5, 1'b1, 1'b0);
    endtask

    task automatic t_idle;
        logic [31:0] held_r;
        logic [3:0]  held_f;
        run_op("R10 setup", 32'd10, 32'd10, 1'b1, 1'b1);
        held_r = result;
        held_f = {flag_n, flag_z, flag_c, flag_v};
        @(negedge clk);
        opa = 32'hDEAD_BEEF; opb = 32'h1234_5678; op_sub = 1'b0; op_setflags = 1'b1;
        op_valid = 1'b0;
        check("R11 idle valid", {31'b0, result_valid}, 32'h0);
        repeat (2) @(negedge clk);
        check("R10 result hold", result, held_r);
        check("R10 flag hold", {28'b0, flag_n, flag_z, flag_c, flag_v}, {28'b0, held_f});
        check("R11 idle valid", {31'b0, result_valid}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_noflag();
        t_idle();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule